// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block maps a plug-in cartridge holding two 8 KB ROM devices, 16 KB in total, into an 8 KB CPU address window split into a lower 4 KB half ($A000-$AFFF) and an upper 4 KB half ($B000-$BFFF). The upper half always shows the upper segment of ROM A. The lower half shows one of three ROM segments or nothing. A separate control bit withdraws both ROMs from the whole window so that system RAM can answer there instead.

Software selects a mapping by writing to any location in the I/O page $D500-$D5FF. The write data is never used. The controller captures the four lowest CPU address bits of that write into a control register, and the register drives the chip enables and the segment-select address line (A12) of each ROM. A conflict output reports the one bit combination that would let both devices claim the lower half. In that case ROM A wins and ROM B stays disabled.

Top module: `cart_bank_mapper`

## Requirements
- R1: A cycle with `wrStrobe` and `ioPageSel` both high loads `cpuAddr[3:0]` into the control register at the clock edge. The register bits are: bit 0 = ROM A lower, bit 1 = ROM B off, bit 2 = ROM B half, bit 3 = RAM. A strobe without the page select, or the page select without the strobe, leaves the register and every output unchanged.
- R2: Reset clears the control register to 0000. After reset, ROM B lower answers in $A000-$AFFF and ROM A upper answers in $B000-$BFFF.
- R3: With bit 3 = 0, an address in $B000-$BFFF inside the window asserts `romAEn` with `romAA12` = 1, whatever bits 0 to 2 hold.
- R4: With bit 3 = 0 and bit 0 = 1, an address in $A000-$AFFF asserts `romAEn` with `romAA12` = 0. With bit 0 = 0, ROM A is not enabled there.
- R5: With bit 3 = 0, bit 1 = 0 and bit 0 = 0, an address in $A000-$AFFF asserts `romBEn`. `romBA12` always equals bit 2, so 0 selects the lower segment and 1 the upper.
- R6: With bit 3 = 1, `ramVisible` is 1 and neither ROM enable is asserted anywhere in the window. With bit 3 = 0, `ramVisible` is 0.
- R7: `mapConflict` is 1 exactly when bit 0 = 1, bit 1 = 0 and bit 3 = 0. In that state ROM A drives $A000-$AFFF and `romBEn` stays low.
- R8: Both ROM enables are low while `winSel` is low, and the two enables are never high in the same cycle.
- R9: A register load becomes visible on the outputs only after the clock edge that captures it. In the cycle of the write itself, the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address bus |
| wrStrobe | input | 1 | CPU write cycle qualifier |
| ioPageSel | input | 1 | High while the address lies in the $D5xx page |
| winSel | input | 1 | High while the address lies in $A000-$BFFF |
| romAEn | output | 1 | Chip enable of ROM A |
| romAA12 | output | 1 | Segment-select line A12 of ROM A |
| romBEn | output | 1 | Chip enable of ROM B |
| romBA12 | output | 1 | Segment-select line A12 of ROM B |
| ramVisible | output | 1 | High when system RAM owns the window |
| mapConflict | output | 1 | Illegal bank combination latched |

## Verification
The assertions assume that `winSel` is high only for addresses in $A000-$BFFF, so that `cpuAddr[12]` tells the two halves apart, and that `ioPageSel` comes from the same decoded address. The stimulus derives both selects from the address it drives, so it never breaks these assumptions. It still produces write strobes outside the page and page accesses with no strobe. It loads all sixteen control codes, including the illegal one, and reads the window at both edges of each half as well as just outside the window.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int CTRL_W = 4;

  // strobes from the control register to the enable datapath
  typedef struct packed {
    logic aLower;   // ROM A lower segment wanted in lower half
    logic bEnable;  // ROM B permitted in lower half (conflict already removed)
    logic bHalf;    // ROM B segment line
    logic ramMode;  // whole window handed to system RAM
    logic clash;    // illegal combination latched
  } mapCtrl_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import cart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic              ioPageSel,
  input  logic [CTRL_W-1:0] addrLow,
  output mapCtrl_t          ctl
);
  localparam int BIT_ALO = 0;
  localparam int BIT_BOFF = 1;
  localparam int BIT_BHALF = 2;
  localparam int BIT_RAM = 3;

  logic [CTRL_W-1:0] bankReg;
  logic              loadEn;

  assign loadEn = wrStrobe & ioPageSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bankReg <= '0;
    else if (loadEn) bankReg <= addrLow;
  end

  logic bothLower;
  assign bothLower = bankReg[BIT_ALO] & ~bankReg[BIT_BOFF];

  always_comb begin
    ctl.ramMode = bankReg[BIT_RAM];
    ctl.aLower  = bankReg[BIT_ALO];
    ctl.bHalf   = bankReg[BIT_BHALF];
    ctl.clash   = bothLower & ~bankReg[BIT_RAM];
    ctl.bEnable = ~bankReg[BIT_BOFF] & ~bankReg[BIT_ALO];
  end
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import cart_bank_pkg::*;
(
  input  mapCtrl_t ctl,
  input  logic     winSel,
  input  logic     upperHalf,
  output logic     romAEn,
  output logic     romAA12,
  output logic     romBEn,
  output logic     romBA12,
  output logic     ramVisible,
  output logic     mapConflict
);
  logic romLive;

  assign romLive = winSel & ~ctl.ramMode;

  always_comb begin
    romAEn      = romLive & (upperHalf | ctl.aLower);
    romAA12     = upperHalf;
    romBEn      = romLive & ~upperHalf & ctl.bEnable;
    romBA12     = ctl.bHalf;
    ramVisible  = ctl.ramMode;
    mapConflict = ctl.clash;
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wrStrobe,
  input  logic              ioPageSel,
  input  logic              winSel,
  output logic              romAEn,
  output logic              romAA12,
  output logic              romBEn,
  output logic              romBA12,
  output logic              ramVisible,
  output logic              mapConflict
);
  mapCtrl_t ctl;
  logic     unusedAddrBits;

  // only the low control bits and the half-select bit matter here
  assign unusedAddrBits = ^cpuAddr;

  bank_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrStrobe  (wrStrobe),
    .ioPageSel (ioPageSel),
    .addrLow   (cpuAddr[CTRL_W-1:0]),
    .ctl       (ctl)
  );

  bank_datapath u_dp (
    .ctl         (ctl),
    .winSel      (winSel),
    .upperHalf   (cpuAddr[SEG_BIT]),
    .romAEn      (romAEn),
    .romAA12     (romAA12),
    .romBEn      (romBEn),
    .romBA12     (romBA12),
    .ramVisible  (ramVisible),
    .mapConflict (mapConflict)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int ADDR_W  = 16,
  parameter int SEG_BIT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              wrStrobe,
  input logic              ioPageSel,
  input logic              winSel,
  input logic              romAEn,
  input logic              romAA12,
  input logic              romBEn,
  input logic              romBA12,
  input logic              ramVisible,
  input logic              mapConflict
);
  p_latch_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && ioPageSel) |=> (ramVisible == $past(cpuAddr[3])));

  p_latch_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && ioPageSel) |=> (romBA12 == $past(cpuAddr[2])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrStrobe && ioPageSel) |=> ($stable(ramVisible) && $stable(romBA12) && $stable(mapConflict)));

  p_upper_rom_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (winSel && cpuAddr[SEG_BIT] && !ramVisible) |-> (romAEn && romAA12));

  p_ram_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ramVisible |-> (!romAEn && !romBEn));

  p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mapConflict |-> !romBEn);

  p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({romAEn, romBEn}) <= 1);

  p_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !winSel |-> (!romAEn && !romBEn));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ADDR_W(ADDR_W), .SEG_BIT(SEG_BIT)) u_chk (.*);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic        wrStrobe = 1'b0;
  logic        ioPageSel = 1'b0;
  logic        winSel = 1'b0;
  logic        romAEn, romAA12, romBEn, romBA12, ramVisible, mapConflict;

  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;
  logic [3:0] model = 4'h0;

  always #10 clk = ~clk;

  cart_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .wrStrobe(wrStrobe),
    .ioPageSel(ioPageSel), .winSel(winSel), .romAEn(romAEn), .romAA12(romAA12),
    .romBEn(romBEn), .romBA12(romBA12), .ramVisible(ramVisible), .mapConflict(mapConflict)
  );

  task automatic checkBit(input string tag, input string name, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b model=%h addr=%h", tag, name, act, exp, model, cpuAddr);
    end
  endtask

  // behavioural expectation from the requirement text
  task automatic compareAll(input string ctx);
    bit inWin, hi, ram, expA, expB, expC;
    string tA, tB;
    inWin = (cpuAddr >= 16'hA000) && (cpuAddr <= 16'hBFFF);
    hi    = cpuAddr[12];
    ram   = model[3];
    expA = 0; expB = 0;
    if (inWin && !ram) begin
      if (hi) expA = 1;
      else if (model[0]) expA = 1;
      else if (!model[1]) expB = 1;
    end
    expC = model[0] && !model[1] && !ram;
    tA = !inWin ? "R8" : (ram ? "R6" : (hi ? "R3" : "R4"));
    tB = !inWin ? "R8" : (ram ? "R6" : (expC ? "R7" : "R5"));
    checkBit({ctx, "/", tA}, "romAEn", romAEn, expA);
    checkBit({ctx, "/", tA}, "romAA12", romAA12, hi);
    checkBit({ctx, "/", tB}, "romBEn", romBEn, expB);
    checkBit({ctx, "/R5"}, "romBA12", romBA12, model[2]);
    checkBit({ctx, "/R6"}, "ramVisible", ramVisible, ram);
    checkBit({ctx, "/R7"}, "mapConflict", mapConflict, expC);
  endtask

  task automatic drive(input logic [15:0] a, input logic wr);
    cpuAddr   = a;
    wrStrobe  = wr;
    ioPageSel = (a[15:8] == 8'hD5);
    winSel    = (a >= 16'hA000) && (a <= 16'hBFFF);
  endtask

  // drive at a falling edge, let one rising edge pass, then compare
  task automatic step(input logic [15:0] a, input logic wr, input string ctx);
    drive(a, wr);
    @(negedge clk);
    if (!rst_n) model = 4'h0;
    else if (wr && (a[15:8] == 8'hD5)) model = a[3:0];
    compareAll(ctx);
  endtask

  task automatic sweep(input string ctx);
    step(16'hA000, 1'b0, ctx);
    step(16'hAFFF, 1'b0, ctx);
    step(16'hB000, 1'b0, ctx);
    step(16'hBFFF, 1'b0, ctx);
    step(16'h9FFF, 1'b0, ctx);
    step(16'hC000, 1'b0, ctx);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(16'hA000, 1'b0, "R2");
    step(16'hD50F, 1'b1, "R2");
    rst_n = 1'b1;
    sweep("R2");

    for (int c = 0; c < 16; c++) begin
      step(16'hD500 | 16'(c), 1'b1, "R1");
      sweep("R1");
    end

    // ignored writes: strobe outside the page, page without strobe
    step(16'hD500, 1'b1, "R1");
    step(16'hD40F, 1'b1, "R1");
    sweep("R1");
    step(16'hD50F, 1'b0, "R1");
    sweep("R1");
    step(16'hA00F, 1'b1, "R1");
    sweep("R1");

    // R9: the outputs keep the old value before the capturing edge
    drive(16'hD50D, 1'b1);
    #1;
    checkBit("R9", "ramVisible", ramVisible, 1'b0);
    checkBit("R9", "mapConflict", mapConflict, 1'b0);
    @(negedge clk);
    model = 4'hD;
    compareAll("R9");

    // asynchronous reset in mid-run
    step(16'hD505, 1'b1, "R1");
    rst_n = 1'b0;
    step(16'hA000, 1'b0, "R2");
    rst_n = 1'b1;
    sweep("R2");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: a = 16'hD500 | 16'($urandom_range(0, 255));
        1: a = 16'hA000 | 16'($urandom_range(0, 4095));
        2: a = 16'hB000 | 16'($urandom_range(0, 4095));
        3: a = 16'($urandom_range(0, 65535));
        default: a = 16'hD400 | 16'($urandom_range(0, 15));
      endcase
      step(a, 1'($urandom_range(0, 1)), "RND");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule